// File: doc/BRIEF.md
# Pausible Local Clock with Request Arbitration

This block generates the local clock of a synchronous island and lets an unclocked neighbour break into that clock at any moment to move data. A two-way mutual-exclusion decision runs in every cycle. One side wants the next rising edge of the local clock. The other side is the neighbour's request line. Only one side is granted. When the neighbour wins, the local clock is frozen low until the neighbour finishes its four-phase handshake.

The model is synthesizable and runs from a faster base clock. A counter sets each half period of the local clock, so the full period is `2*HALF_CYCLES` base cycles. Real metastability resolution is not modelled. When both requests land in the same base cycle, the block takes one extra base cycle to decide, and a parameterized tie rule picks the winner. `TIE_MODE` selects the rule: 0 favours the clock, 1 favours the neighbour, 2 alternates. A refused neighbour keeps its request raised and is served early in the next low phase.

Top module: `pausible_clk_gen`

## Requirements
- R1: While `rst_n` is low, `lclk_out` and `ack_out` are both 0. After reset the clock starts in its low phase.
- R2: With `req_in` held low, `lclk_out` alternates between exactly `HALF_CYCLES` base cycles high and `HALF_CYCLES` base cycles low.
- R3: If `req_in` is sampled high during a low phase, in any low cycle except the last, `ack_out` rises on the next base edge. It then stays high for as long as `req_in` stays high, and `lclk_out` stays low for that whole time.
- R4: `ack_out` falls on the first base edge that samples `req_in` low. `lclk_out` then rises exactly `HALF_CYCLES` base edges after the edge where `ack_out` fell.
- R5: If `req_in` is sampled high in the last low cycle, the clock edge and the request are contested. For one base cycle after that edge, `lclk_out` and `ack_out` both stay 0. On the next base edge exactly one of them rises.
- R6: With `TIE_MODE` = 0, the clock wins a contest and the high phase lasts its full `HALF_CYCLES`. A neighbour that keeps `req_in` high gets `ack_out` one base cycle after `lclk_out` falls.
- R7: With `TIE_MODE` = 1, the neighbour wins a contest: `ack_out` rises and `lclk_out` stays low.
- R8: With `TIE_MODE` = 2, contests alternate between winners, and the first contest after reset goes to the clock.
- R9: `lclk_out` never rises in a cycle where `ack_out` is high or was high in the cycle before.
- R10: A request raised during a high phase has no effect on that phase, which still lasts `HALF_CYCLES` cycles. The request is granted one base cycle after `lclk_out` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock that times the local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 1 | Transfer request from the unclocked neighbour (four-phase) |
| ack_out | output | 1 | Grant to the neighbour; the local clock is frozen while high |
| lclk_out | output | 1 | Pausible local clock |

## Verification
A corrupted phase counter shows up as a high or low phase of the wrong length within one local period, and the bench measures every phase it walks through. A wrong arbitration state shows up on the next base edge after a contest: the clock rises early, the acknowledge rises early, both rise together, or the wrong side wins. The bench places the request in exactly the last low cycle, so the decision cycle and the winner can be read directly at the ports. A grant that releases too soon or late shows up as a misplaced acknowledge fall, or as a restart delay other than one half period.

// File: rtl/pausible_clk_gen.sv
module pausible_clk_gen #(
  parameter int HALF_CYCLES = 4,
  parameter int TIE_MODE    = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  output logic ack_out,
  output logic lclk_out
);

  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  typedef enum logic [1:0] {S_HIGH, S_LOW, S_DECIDE, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          turn;
  logic          due;
  logic          nb_pref;
  logic          nb_take;
  logic          clk_grant;
  logic          nb_grant;

  assign due = (st == S_LOW) && (cnt == LAST);

  generate
    if (TIE_MODE == 1) begin : g_nb_first
      assign nb_pref = 1'b1;
    end else if (TIE_MODE == 2) begin : g_alternate
      assign nb_pref = turn;
    end else begin : g_clk_first
      assign nb_pref = 1'b0;
    end
  endgenerate

  assign nb_take   = nb_pref && req_in;
  assign clk_grant = (due && !req_in) || (st == S_DECIDE && !nb_take);
  assign nb_grant  = (st == S_LOW && !due && req_in) || (st == S_DECIDE && nb_take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_LOW;
      cnt      <= '0;
      turn     <= 1'b0;
      ack_out  <= 1'b0;
      lclk_out <= 1'b0;
    end else begin
      case (st)
        S_HIGH: begin
          if (cnt == LAST) begin
            st       <= S_LOW;
            cnt      <= '0;
            lclk_out <= 1'b0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_LOW: begin
          if (nb_grant) begin
            st      <= S_HOLD;
            ack_out <= 1'b1;
          end else if (due && req_in) begin
            st <= S_DECIDE;
          end else if (clk_grant) begin
            st       <= S_HIGH;
            cnt      <= '0;
            lclk_out <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_DECIDE: begin
          turn <= ~turn;
          if (nb_grant) begin
            st      <= S_HOLD;
            ack_out <= 1'b1;
          end else begin
            st       <= S_HIGH;
            cnt      <= '0;
            lclk_out <= 1'b1;
          end
        end
        default: begin
          if (!req_in) begin
            st      <= S_LOW;
            cnt     <= '0;
            ack_out <= 1'b0;
          end
        end
      endcase
    end
  end

  assert_mutex_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_grant |-> !ack_out);

  assert_no_edge_under_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lclk_out) |-> (!ack_out && !$past(ack_out)));

  assert_ack_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_out && req_in) |=> ack_out);

  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_out) |-> !$past(req_in));

  assert_decide_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (due && req_in) |=> (!lclk_out && !ack_out));

endmodule

// File: tb/pausible_clk_gen_test.sv
module pausible_clk_gen_test;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req_v = 3'b000;
  logic [2:0] ack_v;
  logic [2:0] lclk_v;
  int         n_run = 0;
  int         n_fail = 0;
  int         excl_bad = 0;
  logic [2:0] ack_d = 3'b000;
  logic [2:0] lclk_d = 3'b000;

  always #5 clk = ~clk;

  pausible_clk_gen #(.HALF_CYCLES(H), .TIE_MODE(0)) uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_v[0]), .ack_out(ack_v[0]), .lclk_out(lclk_v[0]));
  pausible_clk_gen #(.HALF_CYCLES(H), .TIE_MODE(1)) uut_nb (
    .clk(clk), .rst_n(rst_n), .req_in(req_v[1]), .ack_out(ack_v[1]), .lclk_out(lclk_v[1]));
  pausible_clk_gen #(.HALF_CYCLES(H), .TIE_MODE(2)) uut_alt (
    .clk(clk), .rst_n(rst_n), .req_in(req_v[2]), .ack_out(ack_v[2]), .lclk_out(lclk_v[2]));

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 3; k++)
        if (lclk_v[k] && !lclk_d[k] && (ack_v[k] || ack_d[k])) excl_bad++;
    end
    ack_d  <= ack_v;
    lclk_d <= lclk_v;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic align_low(input int k);
    do @(negedge clk); while (!lclk_v[k]);
    do @(negedge clk); while (lclk_v[k]);
  endtask

  task automatic count_low(input int k, output int n);
    n = 0;
    while (!lclk_v[k]) begin n++; tick(1); end
  endtask

  task automatic count_high(input int k, output int n);
    n = 0;
    while (lclk_v[k]) begin n++; tick(1); end
  endtask

  task automatic contest(input int k);
    align_low(k);
    tick(H - 1);
    req_v[k] = 1'b1;
    tick(1);
    check(lclk_v[k] == 1'b0, "R5 lclk in decide cycle", lclk_v[k], 0);
    check(ack_v[k] == 1'b0, "R5 ack in decide cycle", ack_v[k], 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(lclk_v[0] == 1'b0, "R1 lclk in reset", lclk_v[0], 0);
    check(ack_v[0] == 1'b0, "R1 ack in reset", ack_v[0], 0);
  endtask

  task automatic t_free_run;
    int n;
    align_low(0);
    count_low(0, n);
    check(n == H, "R2 low phase length", n, H);
    count_high(0, n);
    check(n == H, "R2 high phase length", n, H);
    count_low(0, n);
    check(n == H, "R2 second low phase length", n, H);
  endtask

  task automatic t_grant_hold;
    int n;
    align_low(0);
    tick(1);
    req_v[0] = 1'b1;
    tick(1);
    check(ack_v[0] == 1'b1, "R3 ack rises", ack_v[0], 1);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (lclk_v[0] || !ack_v[0]) n++;
    end
    check(n == 0, "R3 clock frozen while ack", n, 0);
    req_v[0] = 1'b0;
    tick(1);
    check(ack_v[0] == 1'b0, "R4 ack falls", ack_v[0], 0);
    count_low(0, n);
    check(n == H, "R4 restart after half period", n, H);
  endtask

  task automatic t_req_in_high;
    int n;
    do @(negedge clk); while (lclk_v[0]);
    do @(negedge clk); while (!lclk_v[0]);
    req_v[0] = 1'b1;
    count_high(0, n);
    check(n == H, "R10 high phase unaffected", n, H);
    check(ack_v[0] == 1'b0, "R10 no ack at first low cycle", ack_v[0], 0);
    tick(1);
    check(ack_v[0] == 1'b1, "R10 ack one cycle after fall", ack_v[0], 1);
    req_v[0] = 1'b0;
    tick(1);
    check(ack_v[0] == 1'b0, "R10 release", ack_v[0], 0);
  endtask

  task automatic clock_wins(input int k, input string rq);
    tick(1);
    check(lclk_v[k] == 1'b1, {rq, " clock wins"}, lclk_v[k], 1);
    check(ack_v[k] == 1'b0, {rq, " no ack on clock win"}, ack_v[k], 0);
    tick(H - 1);
    check(lclk_v[k] == 1'b1, {rq, " full high phase"}, lclk_v[k], 1);
    tick(1);
    check(lclk_v[k] == 1'b0 && ack_v[k] == 1'b0, {rq, " low, ack pending"}, ack_v[k], 0);
    tick(1);
    check(ack_v[k] == 1'b1, {rq, " refused request served"}, ack_v[k], 1);
    req_v[k] = 1'b0;
    tick(1);
    check(ack_v[k] == 1'b0, {rq, " release"}, ack_v[k], 0);
  endtask

  task automatic nb_wins(input int k, input string rq);
    int n;
    tick(1);
    check(ack_v[k] == 1'b1, {rq, " neighbour wins"}, ack_v[k], 1);
    check(lclk_v[k] == 1'b0, {rq, " clock held"}, lclk_v[k], 0);
    req_v[k] = 1'b0;
    tick(1);
    check(ack_v[k] == 1'b0, {rq, " release"}, ack_v[k], 0);
    count_low(k, n);
    check(n == H, {rq, " restart delay"}, n, H);
  endtask

  task automatic t_tie_clock;
    contest(0);
    clock_wins(0, "R6");
  endtask

  task automatic t_tie_nb;
    contest(1);
    nb_wins(1, "R7");
  endtask

  task automatic t_tie_alt;
    contest(2);
    clock_wins(2, "R8 first");
    contest(2);
    nb_wins(2, "R8 second");
    contest(2);
    clock_wins(2, "R8 third");
  endtask

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    tick(2);
    rst_n = 1'b1;
    t_free_run();
    t_grant_hold();
    t_req_in_high();
    t_tie_clock();
    t_tie_nb();
    t_tie_alt();
    tick(4);
    check(excl_bad == 0, "R9 no edge under ack", excl_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule